// File: doc/BRIEF.md
# Sync-Locked Control Cycle Generator

This block produces the start-of-cycle strobe for a control loop. It runs from the local system clock and is kept phase-locked to an external pulse that arrives once per cycle. The clock frequency is never retuned. Instead, every cycle is given one of two lengths, one slightly shorter and one slightly longer than nominal. The choice follows the sign of the most recent phase measurement, so the accumulated drift is worked off one clock at a time, much like a leap tick.

On each synchronized rising edge of `sync_in`, the block measures how many clocks the pulse lies from the local cycle start. The fixed synchronizer delay is removed and the value is wrapped into plus or minus half a cycle. Two inner-loop strobes divide each cycle into equal parts. Any length correction shows up in them as single-clock gaps. If pulses stop, the tick keeps running with the last selection, and a loss flag is raised.

The controller has three states. FREE is entered at reset and runs at nominal length. LOCK is the tracking state. HOLD is entered when pulses are missing and the last length choice is kept. The transitions are: FREE to LOCK on the first edge, which also restarts the cycle counter once to align it; LOCK to HOLD when the loss limit is reached; HOLD to LOCK on the next edge.

Top module: `scl_cycle_gen`

## Requirements
- R1: While reset is asserted, `cycle_tick` and both `sub_tick` bits are 1, `phase_err` is 0 and `sync_lost` is 0. After release, cycles are NOM_LEN clocks long until the first edge.
- R2: Alignment on the first edge. Let the clock in which `sync_in` is first seen high be clock 0. The next `cycle_tick` is at clock NOM_LEN, and `phase_err` reads 0.
- R3: Phase measurement. Let k be the position of the clock in which `sync_in` is first seen high, counted from the tick clock (tick clock = 0), and let L be the current cycle length. Then `phase_err` becomes k when k <= floor(L/2), and k - L otherwise. The new value is visible 3 clocks after that clock. The value is two's complement, and it changes only after such an edge.
- R4: Length selection. When a cycle starts, its length is NOM_LEN + adj_slow if `phase_err` >= 0, and NOM_LEN + adj_fast if it is negative. `adj_fast` and `adj_slow` are sampled at that moment.
- R5: `adj_fast` and `adj_slow` are signed 6-bit two's complement values, clamped to the range -20..+20 before use.
- R6: In a cycle of length L, `sub_tick[j]` is high at position p when p = 0, or when floor(p*D/L) differs from floor((p-1)*D/L). D is 20 for bit 0 and 5 for bit 1, so each cycle holds exactly D strobes.
- R7: The loss windows run from mid-cycle to mid-cycle, with the boundary at position floor(L/2). `sync_lost` rises one clock after the second consecutive window that contains no edge.
- R8: While no edges arrive, `cycle_tick` continues. Every cycle keeps the length chosen from the held `phase_err`, which stays unchanged.
- R9: `sync_lost` clears 3 clocks after the clock in which `sync_in` is next seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | External once-per-cycle pulse, asynchronous |
| adj_fast | input | 6 | Signed offset for the short cycle |
| adj_slow | input | 6 | Signed offset for the long cycle |
| cycle_tick | output | 1 | High in the first clock of each cycle |
| sub_tick | output | 2 | Inner-loop strobes, [0] divides by 20, [1] by 5 |
| phase_err | output | 24 | Last measured signed phase offset in clocks |
| sync_lost | output | 1 | Pulses missing for two windows |

## Verification
Phase is measured with pulses at the exact half-cycle point, one clock past it, at the cycle start and near the cycle end. These four cases separate the wrap boundary, the sign decision and the latency compensation. Random pulse positions are mixed with random offsets, including values beyond the clamp limits. Each measured cycle length then confirms both the sign-based choice and the clamping. The sub-strobe pattern is compared position by position against the floor formula on short and long cycles. A run of missing pulses, followed by a single returning pulse, separates held-length behaviour from loss detection and from flag clearing.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_LOCK = 2'd1,
        ST_HOLD = 2'd2
    } scl_state_e;

    // Limit a signed offset to +/- lim.
    function automatic int clamp_adj(input int v, input int lim);
        if (v > lim)       return lim;
        else if (v < -lim) return -lim;
        else               return v;
    endfunction

endpackage

// File: rtl/scl_sync_edge.sv
module scl_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/scl_sub_strobe.sv
module scl_sub_strobe #(
    parameter int DIV   = 20,
    parameter int LEN_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [LEN_W-1:0] cur_len,
    output logic             strobe
);
    logic [LEN_W:0] acc;
    logic [LEN_W:0] acc_sum;
    logic [LEN_W:0] len_x;

    assign len_x   = {1'b0, cur_len};
    assign acc_sum = acc + (LEN_W+1)'(DIV);

    // Bresenham-style spreading: DIV strobes per cycle, gaps differ by one clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            strobe <= 1'b1;
        end else if (wrap) begin
            acc    <= '0;
            strobe <= 1'b1;
        end else if (acc_sum >= len_x) begin
            acc    <= acc_sum - len_x;
            strobe <= 1'b1;
        end else begin
            acc    <= acc_sum;
            strobe <= 1'b0;
        end
    end
endmodule

// File: rtl/scl_cycle_gen.sv
module scl_cycle_gen
    import scl_pkg::*;
#(
    parameter int NOM_LEN     = 200000,
    parameter int ADJ_W       = 6,
    parameter int ADJ_LIM     = 20,
    parameter int PH_W        = 24,
    parameter int SYNC_STAGES = 2,
    parameter int MISS_LIMIT  = 2,
    parameter int SUB_DIV0    = 20,
    parameter int SUB_DIV1    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sync_in,
    input  logic signed [ADJ_W-1:0] adj_fast,
    input  logic signed [ADJ_W-1:0] adj_slow,
    output logic                    cycle_tick,
    output logic [1:0]              sub_tick,
    output logic signed [PH_W-1:0]  phase_err,
    output logic                    sync_lost
);
    localparam int MAX_LEN  = NOM_LEN + ADJ_LIM;
    localparam int LEN_W    = $clog2(MAX_LEN + 1);
    localparam int MISS_W   = $clog2(MISS_LIMIT + 1);
    localparam int SYNC_LAT = SYNC_STAGES;

    scl_state_e state, nxt;

    logic [LEN_W-1:0]       cnt, cur_len, next_len, len_fast, len_slow;
    logic [MISS_W-1:0]      miss;
    logic                   seen;
    logic                   sync_rise;
    logic                   last_pos, half_pos, align, wrap;
    logic                   window_miss, lost_hit;
    logic signed [PH_W-1:0] raw, half_s, len_s, meas;

    scl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sync_in),
        .rise (sync_rise)
    );

    // Position decode
    assign last_pos = (cnt == cur_len - 1'b1);
    assign half_pos = (cnt == (cur_len >> 1));
    assign align    = (state == ST_FREE) && sync_rise;
    assign wrap     = last_pos && !align;

    // Cycle length candidates
    always_comb begin
        len_fast = LEN_W'(NOM_LEN + clamp_adj(int'(adj_fast), ADJ_LIM));
        len_slow = LEN_W'(NOM_LEN + clamp_adj(int'(adj_slow), ADJ_LIM));
        if (state == ST_FREE)        next_len = LEN_W'(NOM_LEN);
        else if (phase_err[PH_W-1])  next_len = len_fast;
        else                         next_len = len_slow;
    end

    // Phase of the detected edge, latency removed, wrapped to +/- half cycle
    always_comb begin
        raw    = $signed(PH_W'(cnt)) - $signed(PH_W'(SYNC_LAT));
        half_s = $signed(PH_W'(cur_len >> 1));
        len_s  = $signed(PH_W'(cur_len));
        meas   = (raw > half_s) ? (raw - len_s) : raw;
    end

    // Loss window ends at mid-cycle
    assign window_miss = half_pos && !seen && !sync_rise;
    assign lost_hit    = window_miss && (miss == MISS_W'(MISS_LIMIT - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FREE;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_FREE: if (sync_rise) nxt = ST_LOCK;
            ST_LOCK: if (lost_hit)  nxt = ST_HOLD;
            ST_HOLD: if (sync_rise) nxt = ST_LOCK;
            default: nxt = ST_FREE;
        endcase
    end

    // Counters and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            cur_len   <= LEN_W'(NOM_LEN);
            phase_err <= '0;
            seen      <= 1'b0;
            miss      <= '0;
            sync_lost <= 1'b0;
        end else begin
            if (align) begin
                cnt <= LEN_W'(SYNC_LAT + 1);
            end else if (last_pos) begin
                cnt     <= '0;
                cur_len <= next_len;
            end else begin
                cnt <= cnt + 1'b1;
            end

            if (sync_rise) begin
                phase_err <= (state == ST_FREE) ? '0 : meas;
                sync_lost <= 1'b0;
            end else if (lost_hit) begin
                sync_lost <= 1'b1;
            end

            if (half_pos) begin
                seen <= 1'b0;
                if (!window_miss)                          miss <= '0;
                else if (miss != MISS_W'(MISS_LIMIT))      miss <= miss + 1'b1;
            end else if (sync_rise) begin
                seen <= 1'b1;
                miss <= '0;
            end
        end
    end

    assign cycle_tick = (cnt == '0);

    for (genvar g = 0; g < 2; g++) begin : g_sub
        localparam int DIV = (g == 0) ? SUB_DIV0 : SUB_DIV1;
        scl_sub_strobe #(.DIV(DIV), .LEN_W(LEN_W)) u_sub (
            .clk    (clk),
            .rst_n  (rst_n),
            .wrap   (wrap),
            .cur_len(cur_len),
            .strobe (sub_tick[g])
        );
    end
endmodule

// File: rtl/scl_cycle_gen_chk.sv
module scl_cycle_gen_chk #(
    parameter int NOM_LEN = 200000,
    parameter int ADJ_LIM = 20,
    parameter int PH_W    = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sync_in,
    input logic                   cycle_tick,
    input logic [1:0]             sub_tick,
    input logic signed [PH_W-1:0] phase_err,
    input logic                   sync_lost
);
    localparam int GAP_MAX = 2 * (NOM_LEN + ADJ_LIM);
    localparam int GW      = $clog2(GAP_MAX + 1);
    localparam logic signed [PH_W-1:0] PH_MAX = PH_W'(NOM_LEN / 2 + ADJ_LIM);
    localparam logic signed [PH_W-1:0] PH_MIN = -PH_MAX;

    logic [GW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          gap <= '0;
        else if (cycle_tick) gap <= '0;
        else if (gap != '1)  gap <= gap + 1'b1;
    end

    AST_TICK_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        gap < GW'(GAP_MAX)); // R8

    AST_STROBES_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_tick |-> (&sub_tick)); // R6

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_tick |=> !cycle_tick); // R4

    AST_PHASE_WRAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_err <= PH_MAX) && (phase_err >= PH_MIN)); // R3

    AST_PHASE_ONLY_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_err) |-> $past(sync_in, 3)); // R3

    AST_LOST_CLEARS_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_lost) |-> $past(sync_in, 3)); // R9
endmodule

bind scl_cycle_gen scl_cycle_gen_chk #(
    .NOM_LEN(NOM_LEN),
    .ADJ_LIM(ADJ_LIM),
    .PH_W   (PH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .cycle_tick(cycle_tick),
    .sub_tick  (sub_tick),
    .phase_err (phase_err),
    .sync_lost (sync_lost)
);

// File: tb/tb_scl_cycle_gen.sv
module tb_scl_cycle_gen;
    localparam int NOM = 200;
    localparam int LIM = 20;
    localparam int PHW = 24;
    localparam int D0  = 20;
    localparam int D1  = 5;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  sync_in = 1'b0;
    logic signed [5:0]     adj_fast = '0;
    logic signed [5:0]     adj_slow = '0;
    logic                  cycle_tick;
    logic [1:0]            sub_tick;
    logic signed [PHW-1:0] phase_err;
    logic                  sync_lost;

    always #10 clk = ~clk;

    scl_cycle_gen #(
        .NOM_LEN(NOM), .ADJ_LIM(LIM), .PH_W(PHW), .SUB_DIV0(D0), .SUB_DIV1(D1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .adj_fast(adj_fast), .adj_slow(adj_slow),
        .cycle_tick(cycle_tick), .sub_tick(sub_tick),
        .phase_err(phase_err), .sync_lost(sync_lost)
    );

    int n_tests = 0, n_fail = 0;
    int tpos = 0, last_int = 0, cur_exp = NOM, sub_bad = 0;
    int fast_v = 0, slow_v = 0;
    bit mon_en = 1'b0;

    function automatic int clampv(int v);
        return (v > LIM) ? LIM : ((v < -LIM) ? -LIM : v);
    endfunction

    function automatic bit sub_exp(int p, int len, int d);
        if (p == 0) return 1'b1;
        return ((p * d) / len) != (((p - 1) * d) / len);
    endfunction

    function automatic int wrap_ph(int k, int len);
        return (k <= len / 2) ? k : k - len;
    endfunction

    task automatic check(string req, bit ok, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (cycle_tick) begin
            last_int = tpos + 1;
            tpos = 0;
        end else begin
            tpos++;
        end
        if (mon_en) begin
            if (sub_tick[0] !== sub_exp(tpos, cur_exp, D0)) sub_bad++;
            if (sub_tick[1] !== sub_exp(tpos, cur_exp, D1)) sub_bad++;
        end
    endtask

    task automatic wait_tick();
        do step(); while (!cycle_tick);
    endtask

    task automatic set_adj(int f, int s);
        fast_v   = f;
        slow_v   = s;
        adj_fast = 6'(f);
        adj_slow = 6'(s);
    endtask

    task automatic pulse_at(int k);
        while (tpos < k) step();
        sync_in = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n, ph, last_ph, held, nxt;
        void'($urandom(32'd4711));
        set_adj(-5, 7);
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1", cycle_tick == 1'b1, cycle_tick, 1);
        check("R1", sub_tick == 2'b11, sub_tick, 3);
        check("R1", phase_err == 0, int'(phase_err), 0);
        check("R1", sync_lost == 1'b0, sync_lost, 0);
        rst_n = 1'b1;
        tpos  = 0;
        wait_tick();
        check("R1", last_int == NOM, last_int, NOM);

        // R7: loss flag in the second window without edges
        while (tpos < 100) step();
        check("R7", sync_lost == 1'b0, sync_lost, 0);
        step();
        check("R7", sync_lost == 1'b1, sync_lost, 1);

        // R2: alignment on the first edge
        pulse_at(150);
        n = 0;
        do begin
            step();
            n++;
            if (n == 3) sync_in = 1'b0;
        end while (!cycle_tick);
        check("R2", n == NOM, n, NOM);
        check("R2", phase_err == 0, int'(phase_err), 0);
        check("R9", sync_lost == 1'b0, sync_lost, 0);

        cur_exp = NOM + clampv(slow_v);
        mon_en  = 1'b1;
        sub_bad = 0;
        last_ph = 0;

        for (int it = 0; it < 40; it++) begin
            int k;
            case (it)
                0:       k = cur_exp / 2;
                1:       k = cur_exp / 2 + 1;
                2:       k = 0;
                3:       k = cur_exp - 4;
                default: k = $urandom_range(0, cur_exp - 4);
            endcase
            pulse_at(k);
            ph = wrap_ph(k, cur_exp);
            repeat (3) step();
            sync_in = 1'b0;
            check("R3", phase_err == ph, int'(phase_err), ph);
            case (it)
                0: set_adj(-32, 31);
                1: set_adj(-21, 21);
                2: set_adj(20, -20);
                3: set_adj(0, 0);
                default: begin
                    int rf, rs;
                    rf = $urandom_range(0, 63);
                    rs = $urandom_range(0, 63);
                    set_adj((rf >= 32) ? rf - 64 : rf, (rs >= 32) ? rs - 64 : rs);
                end
            endcase
            nxt = NOM + clampv((ph < 0) ? fast_v : slow_v);
            wait_tick();
            check("R4", last_int == cur_exp, last_int, cur_exp);
            check("R6", sub_bad == 0, sub_bad, 0);
            if (it >= 1 && it <= 2) check("R5", cur_exp <= NOM + LIM && cur_exp >= NOM - LIM, cur_exp, NOM);
            sub_bad = 0;
            cur_exp = nxt;
            last_ph = ph;
        end

        // R8: no edges, lengths held, ticks continue
        mon_en = 1'b0;
        held = NOM + clampv((last_ph < 0) ? fast_v : slow_v);
        for (int h = 0; h < 4; h++) begin
            wait_tick();
            check("R8", last_int == cur_exp, last_int, cur_exp);
            check("R8", phase_err == last_ph, int'(phase_err), last_ph);
            cur_exp = held;
        end
        check("R7", sync_lost == 1'b1, sync_lost, 1);

        // R9: flag clears with the returning edge
        pulse_at(10);
        step();
        step();
        check("R9", sync_lost == 1'b1, sync_lost, 1);
        step();
        sync_in = 1'b0;
        check("R9", sync_lost == 1'b0, sync_lost, 0);
        check("R3", phase_err == 10, int'(phase_err), 10);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule